// File: doc/BRIEF.md
# Command-Driven System Management Controller

This block is a mailbox-style controller that a host CPU drives over a small byte-wide register bus. The host loads up to seven parameter bytes, writes a command code, and then sets a busy flag. In the cycle after the flag is set, the controller decodes the code and performs its side effect. It writes its result into a bank of thirty-two result bytes and clears the flag, which tells the host the command has finished.

The side effects cover several things:
- sequencing reset and enable lines for four subordinate units: a secondary CPU, a sound processor, a disc subsystem and a modem unit;
- pulsing a reset line for the master CPU and for the whole system;
- selecting one of two clock-speed modes;
- latching a seven-byte time value and a four-byte retained-memory word onto output buses;
- raising an NMI toward the master CPU.

A reset-button input is synchronised and edge-detected. Each rising edge of the button produces an NMI, but only while the host has enabled button NMIs. The status-fetch command returns computed placeholder data instead of real peripheral data.

Top module: `sysmgr_ctrl`

## Requirements
- R1: Parameter byte k (k = 0..6) is written and read back at bus address 2k+1 (0x01..0x0D). The command byte sits at 0x1F, and reads return the last accepted code.
- R2: Writing a value with bit 0 set to address 0x63 sets the busy flag, which reads back as 0x01. On the next clock edge the command executes and the flag reads 0x00. For every recognised code other than 0x10, result byte 31 (address 0x5F) then reads the executed code.
- R3: Codes 0x02, 0x06, 0x08 and 0x0A turn on unit 0 (secondary CPU), unit 1 (sound), unit 2 (disc) and unit 3 (modem) respectively. The chosen unit's `unit_en` bit rises at execution. Its `unit_rst` bit stays high for exactly RST_CYC cycles after execution and then falls while enable stays high.
- R4: Codes 0x03, 0x07, 0x09 and 0x0B turn units 0..3 off, which clears the unit's enable and holds its reset high. After reset, all units are off.
- R5: Code 0x00 drives `mst_rst` high for exactly RST_CYC cycles after execution. Code 0x0D does the same on `sys_rst`.
- R6: `clk_sel` is 0 after reset. Code 0x0E sets it to 1 and code 0x0F sets it to 0. A command that changes `clk_sel` also pulses `sys_rst` for RST_CYC cycles; a command that leaves it unchanged does not.
- R7: Code 0x16 copies parameter byte k onto `time_val[8k+7:8k]` for k = 0..6. Code 0x17 copies parameter bytes 0..3 onto `ret_mem[8k+7:8k]`.
- R8: Code 0x10 writes result byte i (address 0x21+2i, i = 0..31) with the value i XOR parameter byte 0.
- R9: Code 0x18 makes `nmi_out` high for exactly one cycle, starting at execution.
- R10: A rising edge on `reset_btn` gives one `nmi_out` pulse one cycle long, three clock edges after the input changes, but only while button NMIs are enabled. Code 0x19 enables them and code 0x1A disables them. They are disabled after reset.
- R11: An unrecognised code only clears the flag, and result byte 31 keeps its value. A command-byte write while the flag is set is ignored.
- R12: The status byte at 0x61 reads bit 0 = button-NMI enable and bit 1 = `clk_sel`, with the other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte address of register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| reset_btn | input | 1 | Asynchronous reset-button level |
| mst_rst | output | 1 | Master CPU reset pulse |
| sys_rst | output | 1 | System reset pulse |
| unit_en | output | 4 | Enables: secondary CPU, sound, disc, modem (bits 0..3) |
| unit_rst | output | 4 | Resets for the same units |
| clk_sel | output | 1 | Clock-speed mode select |
| nmi_out | output | 1 | One-cycle NMI request to master CPU |
| time_val | output | 56 | Latched time value |
| ret_mem | output | 32 | Retained-memory word |

## Verification
A stuck or mis-timed busy flag shows up at address 0x63 one edge after the host sets it. A wrong command decode shows up at the same edge in result byte 31 and on the unit enables. Reset-hold counters that load or count wrongly make `unit_rst`, `mst_rst` or `sys_rst` fall one or more cycles early or late, which is visible exactly RST_CYC cycles after execution. A mis-tracked clock mode or button-enable state appears in the status byte right away, and as a missing or extra `sys_rst` or `nmi_out` pulse within three cycles.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam logic [7:0] C_MST_ON  = 8'h00;
  localparam logic [7:0] C_SLV_ON  = 8'h02;
  localparam logic [7:0] C_SLV_OFF = 8'h03;
  localparam logic [7:0] C_SND_ON  = 8'h06;
  localparam logic [7:0] C_SND_OFF = 8'h07;
  localparam logic [7:0] C_DSC_ON  = 8'h08;
  localparam logic [7:0] C_DSC_OFF = 8'h09;
  localparam logic [7:0] C_MDM_ON  = 8'h0A;
  localparam logic [7:0] C_MDM_OFF = 8'h0B;
  localparam logic [7:0] C_SYS_RST = 8'h0D;
  localparam logic [7:0] C_CLK_HI  = 8'h0E;
  localparam logic [7:0] C_CLK_LO  = 8'h0F;
  localparam logic [7:0] C_FETCH   = 8'h10;
  localparam logic [7:0] C_TIME    = 8'h16;
  localparam logic [7:0] C_MEM     = 8'h17;
  localparam logic [7:0] C_NMI     = 8'h18;
  localparam logic [7:0] C_BTN_EN  = 8'h19;
  localparam logic [7:0] C_BTN_DIS = 8'h1A;

  localparam int NUM_UNITS = 4;

  function automatic logic cmd_known(input logic [7:0] c);
    case (c)
      C_MST_ON, C_SLV_ON, C_SLV_OFF, C_SND_ON, C_SND_OFF, C_DSC_ON,
      C_DSC_OFF, C_MDM_ON, C_MDM_OFF, C_SYS_RST, C_CLK_HI, C_CLK_LO,
      C_FETCH, C_TIME, C_MEM, C_NMI, C_BTN_EN, C_BTN_DIS: cmd_known = 1'b1;
      default: cmd_known = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/smc_pulse.sv
module smc_pulse #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYC);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start)             cnt_n = LOAD;
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/smc_unit.sv
module smc_unit #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_req,
  input  logic off_req,
  output logic en,
  output logic rst_o
);
  logic en_q, en_n, hold;

  always_comb begin
    en_n = en_q;
    if (on_req)       en_n = 1'b1;
    else if (off_req) en_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_n;
  end

  smc_pulse #(.CYC(CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .start(on_req), .busy(hold)
  );

  assign en    = en_q;
  assign rst_o = !en_q || hold;
endmodule

// File: rtl/smc_btn.sv
module smc_btn (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_async,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= btn_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q && !s3_q;
endmodule

// File: rtl/sysmgr_ctrl.sv
module sysmgr_ctrl #(
  parameter int RST_CYC = 4,
  parameter int N_IN    = 7,
  parameter int N_OUT   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        reset_btn,
  output logic        mst_rst,
  output logic        sys_rst,
  output logic [3:0]  unit_en,
  output logic [3:0]  unit_rst,
  output logic        clk_sel,
  output logic        nmi_out,
  output logic [55:0] time_val,
  output logic [31:0] ret_mem
);
  import smc_pkg::*;

  localparam logic [6:0] A_IN_LAST = 7'(2 * N_IN - 1);
  localparam logic [6:0] A_CMD     = 7'h1F;
  localparam logic [6:0] A_OUT_0   = 7'h21;
  localparam logic [6:0] A_OUT_END = 7'(8'h21 + 2 * (N_OUT - 1));
  localparam logic [6:0] A_STAT    = 7'h61;
  localparam logic [6:0] A_FLAG    = 7'h63;
  localparam int         OW        = $clog2(N_OUT);
  localparam int         MEM_B     = 4;

  logic [7:0] in_q  [N_IN];
  logic [7:0] out_q [N_OUT];
  logic [7:0] cmd_q, cmd_n;
  logic       flag_q, flag_n;
  logic       clk_q, clk_n;
  logic       ben_q, ben_n;
  logic       nmi_q, nmi_n;
  logic [55:0] time_q;
  logic [31:0] mem_q;

  // bus decode
  logic       in_hit, out_hit, cmd_wr, flag_wr;
  logic [5:0] out_off;
  assign in_hit  = bus_addr[0] && (bus_addr <= A_IN_LAST);
  assign out_hit = bus_addr[0] && (bus_addr >= A_OUT_0) && (bus_addr <= A_OUT_END);
  assign out_off = bus_addr[6:1] - 6'(A_OUT_0 >> 1);
  assign cmd_wr  = bus_wr && (bus_addr == A_CMD);
  assign flag_wr = bus_wr && (bus_addr == A_FLAG) && bus_wdata[0];

  // command decode
  logic       exec, known, fetch, mst_go, sys_cmd, clk_w, clk_v;
  logic       time_ld, mem_ld, nmi_cmd, ben_set, ben_clr, sys_go;
  logic [3:0] u_on, u_off;
  logic       btn_rise;

  always_comb begin
    exec    = flag_q;
    known   = cmd_known(cmd_q);
    fetch   = 1'b0; mst_go = 1'b0; sys_cmd = 1'b0; clk_w = 1'b0; clk_v = 1'b0;
    time_ld = 1'b0; mem_ld = 1'b0; nmi_cmd = 1'b0; ben_set = 1'b0; ben_clr = 1'b0;
    u_on    = '0;   u_off  = '0;
    if (exec) begin
      case (cmd_q)
        C_MST_ON:  mst_go   = 1'b1;
        C_SLV_ON:  u_on[0]  = 1'b1;
        C_SLV_OFF: u_off[0] = 1'b1;
        C_SND_ON:  u_on[1]  = 1'b1;
        C_SND_OFF: u_off[1] = 1'b1;
        C_DSC_ON:  u_on[2]  = 1'b1;
        C_DSC_OFF: u_off[2] = 1'b1;
        C_MDM_ON:  u_on[3]  = 1'b1;
        C_MDM_OFF: u_off[3] = 1'b1;
        C_SYS_RST: sys_cmd  = 1'b1;
        C_CLK_HI:  begin clk_w = 1'b1; clk_v = 1'b1; end
        C_CLK_LO:  begin clk_w = 1'b1; clk_v = 1'b0; end
        C_FETCH:   fetch    = 1'b1;
        C_TIME:    time_ld  = 1'b1;
        C_MEM:     mem_ld   = 1'b1;
        C_NMI:     nmi_cmd  = 1'b1;
        C_BTN_EN:  ben_set  = 1'b1;
        C_BTN_DIS: ben_clr  = 1'b1;
        default:   ;
      endcase
    end
    sys_go = sys_cmd || (clk_w && (clk_v != clk_q));
  end

  // next state for control registers
  always_comb begin
    flag_n = exec ? 1'b0 : (flag_wr ? 1'b1 : flag_q);
    cmd_n  = (cmd_wr && !flag_q) ? bus_wdata : cmd_q;
    clk_n  = clk_w ? clk_v : clk_q;
    ben_n  = ben_set ? 1'b1 : (ben_clr ? 1'b0 : ben_q);
    nmi_n  = nmi_cmd || (btn_rise && ben_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cmd_q  <= '0;
      clk_q  <= 1'b0;
      ben_q  <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      cmd_q  <= cmd_n;
      clk_q  <= clk_n;
      ben_q  <= ben_n;
      nmi_q  <= nmi_n;
    end
  end

  // parameter bytes
  for (genvar k = 0; k < N_IN; k++) begin : g_in
    logic wr_en;
    assign wr_en = bus_wr && in_hit && (bus_addr[6:1] == 6'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     in_q[k] <= '0;
      else if (wr_en) in_q[k] <= bus_wdata;
    end
  end

  // result bytes
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic       ld;
    logic [7:0] val;
    if (i == N_OUT - 1) begin : g_last
      assign ld  = exec && known;
      assign val = fetch ? (8'(i) ^ in_q[0]) : cmd_q;
    end else begin : g_body
      assign ld  = fetch;
      assign val = 8'(i) ^ in_q[0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  out_q[i] <= '0;
      else if (ld) out_q[i] <= val;
    end
  end

  // time and retained memory latches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      mem_q  <= '0;
    end else begin
      if (time_ld) for (int k = 0; k < N_IN; k++) time_q[8*k +: 8] <= in_q[k];
      if (mem_ld)  for (int k = 0; k < MEM_B; k++) mem_q[8*k +: 8] <= in_q[k];
    end
  end

  // unit sequencers
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    smc_unit #(.CYC(RST_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .on_req(u_on[u]), .off_req(u_off[u]),
      .en(unit_en[u]), .rst_o(unit_rst[u])
    );
  end

  smc_pulse #(.CYC(RST_CYC)) u_mst (.clk(clk), .rst_n(rst_n), .start(mst_go), .busy(mst_rst));
  smc_pulse #(.CYC(RST_CYC)) u_sys (.clk(clk), .rst_n(rst_n), .start(sys_go), .busy(sys_rst));
  smc_btn u_btn (.clk(clk), .rst_n(rst_n), .btn_async(reset_btn), .rise(btn_rise));

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (in_hit)                  bus_rdata = in_q[bus_addr[3:1]];
    else if (out_hit)            bus_rdata = out_q[out_off[OW-1:0]];
    else if (bus_addr == A_CMD)  bus_rdata = cmd_q;
    else if (bus_addr == A_STAT) bus_rdata = {6'b0, clk_q, ben_q};
    else if (bus_addr == A_FLAG) bus_rdata = {7'b0, flag_q};
  end

  assign clk_sel  = clk_q;
  assign nmi_out  = nmi_q;
  assign time_val = time_q;
  assign ret_mem  = mem_q;
endmodule

// File: rtl/smc_chk.sv
module smc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flag_q,
  input logic [7:0] cmd_q,
  input logic [7:0] last_out,
  input logic       cmd_wr,
  input logic [3:0] unit_en,
  input logic [3:0] unit_rst,
  input logic       clk_sel,
  input logic       sys_rst
);
  import smc_pkg::*;

  p_flag_self_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> !flag_q);

  p_result_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && cmd_known(cmd_q) && cmd_q != C_FETCH) |=> last_out == $past(cmd_q));

  p_off_holds_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_rst | unit_en) == 4'hF);

  p_release_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unit_rst[0]) |-> unit_en[0]);

  p_clk_change_sysrst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_sel) || $fell(clk_sel)) |-> sys_rst);

  p_cmd_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && cmd_wr) |=> $stable(cmd_q));

  p_unknown_keeps_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !cmd_known(cmd_q)) |=> $stable(last_out));
endmodule

bind sysmgr_ctrl smc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .cmd_q(cmd_q),
  .last_out(out_q[N_OUT-1]), .cmd_wr(cmd_wr), .unit_en(unit_en),
  .unit_rst(unit_rst), .clk_sel(clk_sel), .sys_rst(sys_rst)
);

// File: tb/tb_sysmgr_ctrl.sv
module tb_sysmgr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RC = 4;

  logic clk, rst_n, bus_wr, reset_btn;
  logic [6:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic mst_rst, sys_rst, clk_sel, nmi_out;
  logic [3:0] unit_en, unit_rst;
  logic [55:0] time_val;
  logic [31:0] ret_mem;

  int checks = 0, errors = 0;
  bit done = 0;

  sysmgr_ctrl #(.RST_CYC(RC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_btn(reset_btn),
    .mst_rst(mst_rst), .sys_rst(sys_rst), .unit_en(unit_en), .unit_rst(unit_rst),
    .clk_sel(clk_sel), .nmi_out(nmi_out), .time_val(time_val), .ret_mem(ret_mem)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {code, expected unit_en after execution}
  localparam logic [11:0] VEC [10] = '{
    {8'h02, 4'b0001}, {8'h06, 4'b0011}, {8'h08, 4'b0111}, {8'h0A, 4'b1111},
    {8'h03, 4'b1110}, {8'h07, 4'b1100}, {8'h09, 4'b1000}, {8'h0B, 4'b0000},
    {8'h02, 4'b0001}, {8'h0A, 4'b1001}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // returns just after the execution edge
  task automatic issue(input logic [7:0] code);
    wr(7'h1F, code);
    wr(7'h63, 8'h01);
    @(posedge clk); #1;
  endtask

  task automatic count_nmi(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (nmi_out) c++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int c;
    rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; reset_btn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // reset state
    #1;
    chk(unit_en == 4'h0 && unit_rst == 4'hF, "R4 reset units", {unit_en, unit_rst}, 8'h0F);
    chk(clk_sel == 0 && nmi_out == 0 && sys_rst == 0 && mst_rst == 0, "R6 reset outputs",
        {clk_sel, nmi_out, sys_rst, mst_rst}, 0);
    rd(7'h61, d); chk(d == 8'h00, "R12 status after reset", d, 0);

    // R1 parameter bytes
    for (int k = 0; k < 7; k++) wr(7'(2*k+1), 8'hA0 + 8'(k));
    for (int k = 0; k < 7; k++) begin
      rd(7'(2*k+1), d); chk(d == 8'hA0 + 8'(k), "R1 param readback", d, 8'hA0 + k);
    end

    // R2 flag handshake
    wr(7'h1F, 8'h19);
    rd(7'h1F, d); chk(d == 8'h19, "R1 command readback", d, 8'h19);
    wr(7'h63, 8'h01);
    // at W+0.5: flag set, exec at next edge
    rd(7'h63, d); chk(d == 8'h01, "R2 flag set", d, 1);
    @(posedge clk); #1;
    rd(7'h63, d); chk(d == 8'h00, "R2 flag cleared", d, 0);
    rd(7'h5F, d); chk(d == 8'h19, "R2 result byte 31", d, 8'h19);
    rd(7'h61, d); chk(d == 8'h01, "R12 status button enable", d, 1);
    issue(8'h1A);
    rd(7'h61, d); chk(d == 8'h00, "R12 status button disable", d, 0);

    // R3/R4 unit table
    for (int v = 0; v < 10; v++) begin
      logic [7:0] code; logic [3:0] en;
      code = VEC[v][11:4]; en = VEC[v][3:0];
      issue(code);
      chk(unit_en == en, "R3 R4 enable pattern", unit_en, en);
      rd(7'h5F, d); chk(d == code, "R2 result code", d, code);
      repeat (RC) @(posedge clk); #1;
      chk(unit_rst == ~en, "R3 R4 reset pattern", unit_rst, ~en);
    end

    // R3 exact hold length on sound unit
    issue(8'h06);
    chk(unit_en[1] && unit_rst[1], "R3 hold start", {unit_en[1], unit_rst[1]}, 2'b11);
    repeat (RC-1) @(posedge clk); #1;
    chk(unit_rst[1] == 1, "R3 hold last cycle", unit_rst[1], 1);
    @(posedge clk); #1;
    chk(unit_rst[1] == 0 && unit_en[1], "R3 release", unit_rst[1], 0);

    // R5 master and system pulses
    issue(8'h00);
    chk(mst_rst == 1, "R5 master start", mst_rst, 1);
    repeat (RC-1) @(posedge clk); #1;
    chk(mst_rst == 1, "R5 master last", mst_rst, 1);
    @(posedge clk); #1;
    chk(mst_rst == 0, "R5 master end", mst_rst, 0);
    issue(8'h0D);
    chk(sys_rst == 1, "R5 system start", sys_rst, 1);
    repeat (RC) @(posedge clk); #1;
    chk(sys_rst == 0, "R5 system end", sys_rst, 0);

    // R6 clock select
    issue(8'h0E);
    chk(clk_sel == 1 && sys_rst == 1, "R6 high mode with reset", {clk_sel, sys_rst}, 2'b11);
    rd(7'h61, d); chk(d == 8'h02, "R12 status clock bit", d, 2);
    repeat (RC) @(posedge clk); #1;
    issue(8'h0E);
    chk(clk_sel == 1 && sys_rst == 0, "R6 same mode no reset", {clk_sel, sys_rst}, 2'b10);
    issue(8'h0F);
    chk(clk_sel == 0 && sys_rst == 1, "R6 low mode with reset", {clk_sel, sys_rst}, 2'b01);
    repeat (RC) @(posedge clk); #1;

    // R7 time and retained memory
    issue(8'h16);
    chk(time_val == 56'hA6A5A4A3A2A1A0, "R7 time value", time_val, 56'hA6A5A4A3A2A1A0);
    for (int k = 0; k < 4; k++) wr(7'(2*k+1), 8'h10 * 8'(k+1) + 8'h5);
    issue(8'h17);
    chk(ret_mem == 32'h45352515, "R7 retained memory", ret_mem, 32'h45352515);

    // R8 fetch placeholder
    wr(7'h01, 8'h3C);
    issue(8'h10);
    for (int i = 0; i < 32; i++) begin
      rd(7'(8'h21 + 2*i), d);
      chk(d == (8'(i) ^ 8'h3C), "R8 fetch result", d, 8'(i) ^ 8'h3C);
    end

    // R9 NMI command
    issue(8'h18);
    chk(nmi_out == 1, "R9 nmi start", nmi_out, 1);
    @(posedge clk); #1;
    chk(nmi_out == 0, "R9 nmi one cycle", nmi_out, 0);

    // R10 reset button
    @(negedge clk); reset_btn = 1;
    count_nmi(6, c); chk(c == 0, "R10 disabled after reset", c, 0);
    reset_btn = 0;
    issue(8'h19);
    repeat (4) @(posedge clk);
    @(negedge clk); reset_btn = 1;
    repeat (2) @(posedge clk); #1;
    chk(nmi_out == 0, "R10 not before third edge", nmi_out, 0);
    @(posedge clk); #1;
    chk(nmi_out == 1, "R10 pulse at third edge", nmi_out, 1);
    count_nmi(5, c); chk(c == 0, "R10 single pulse", c, 0);
    reset_btn = 0;
    issue(8'h1A);
    repeat (4) @(posedge clk);
    @(negedge clk); reset_btn = 1;
    count_nmi(6, c); chk(c == 0, "R10 disabled again", c, 0);
    reset_btn = 0;

    // R11 unknown code and locked command
    issue(8'h1A);
    issue(8'h05);
    rd(7'h63, d); chk(d == 8'h00, "R11 unknown clears flag", d, 0);
    rd(7'h5F, d); chk(d == 8'h1A, "R11 unknown keeps result", d, 8'h1A);
    wr(7'h1F, 8'h03);
    @(negedge clk); bus_addr = 7'h63; bus_wdata = 8'h01; bus_wr = 1;
    @(negedge clk); bus_addr = 7'h1F; bus_wdata = 8'h0B; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    rd(7'h1F, d); chk(d == 8'h03, "R11 locked command byte", d, 8'h03);
    rd(7'h5F, d); chk(d == 8'h03, "R11 executed original code", d, 8'h03);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule